// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block switches one derived clock on and off under an asynchronous, active-low stop request, while passing an untouched copy of the same clock to loads that must never stop. The request is brought into the clock domain through a reset-to-stopped synchronizer chain. A small controller then decides whether the gated clock runs or parks. The enable it produces is re-timed on the falling edge and ANDed with the clock. Because of this, the gated output can change only while the clock is low: it parks low, and every restart begins with a whole high phase.

After each restart the controller insists on a minimum number of gated pulses before it honours a new stop, so a stop that arrives early is held back rather than dropped. A separate force-low input, meant for a power-down sequencer, overrides both the stop request and the minimum-run rule. Parameters set the synchronizer depth, the minimum run, and extra delay in the start and stop paths. The same block can therefore sit in a fast processor domain (for example MIN_RUN=100, ON_EXTRA=1) or a slow bus domain (the defaults).

Top module: `clk_stop_gate`

## Requirements
Edge numbering counts rising edges of clk_in. "Pulse at edge n" means clk_gated is high during the high phase that begins at edge n. Unless noted, timing is given for SYNC_STAGES=2, ON_EXTRA=0, OFF_EXTRA=0 and MIN_RUN=10.
- R1: While rst_n is low, clk_gated is low. After rst_n rises with stop_n already high, the first three edges carry no pulse.
- R2: clk_free equals clk_in at all times, whatever stop_n, force_low or rst_n do.
- R3: clk_gated is low whenever clk_in is low. Each pulse starts on a clk_in rising edge and stays high for the whole high phase of clk_in.
- R4: Once parked, clk_gated stays low on every later edge until a start is accepted.
- R5: When the gate is running with its minimum run met and stop_n is first sampled low at edge a, pulses still appear at edges a through a+SYNC_STAGES+OFF_EXTRA. No pulse follows.
- R6: When the gate is parked and stop_n is first sampled high at edge b, the first pulse appears at edge b+SYNC_STAGES+ON_EXTRA+1. There is no pulse before it.
- R7: After every start, at least MIN_RUN pulses are produced before the gate parks, unless force_low is used. A stop seen earlier is deferred, and the gate parks right after the MIN_RUN-th pulse.
- R8: A stop_n low pulse sampled at a single edge, while the minimum run is met, still removes exactly one pulse: pulses at a..a+2, none at a+3, pulses again from a+4.
- R9: When force_low is first sampled high at edge f, the last pulse is at edge f+SYNC_STAGES, whatever the minimum-run count.
- R10: While force_low is held high, stop_n has no effect and clk_gated stays low. After force_low is sampled low at edge g with stop_n high, the first pulse is at edge g+SYNC_STAGES+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset; parks the gate |
| stop_n | input | 1 | Asynchronous stop request, low = stop |
| force_low | input | 1 | Asynchronous override, high = park now |
| clk_gated | output | 1 | Gated clock, parked low |
| clk_free | output | 1 | Ungated copy of clk_in |

## Verification
If the enable register or the run state holds a wrong value, the pulse train shows it at once. A pulse appears or goes missing at a specific edge, within SYNC_STAGES+1 edges of the triggering input change. A miscounted minimum run moves the parking edge after an early stop by whole cycles. An enable sampled on the wrong clock edge shows up within the same cycle: the output rises late or falls inside a high phase. The scoreboard keeps one expected bit per edge and also samples late in the high phase and during the low phase, so each of these errors is caught on the first cycle where it appears.

// File: rtl/stop_gate_pkg.sv
package stop_gate_pkg;
   typedef enum logic {
      GATE_PARKED  = 1'b0,
      GATE_RUNNING = 1'b1
   } gate_state_e;
endpackage

// File: rtl/sg_sync_chain.sv
module sg_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sg_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sg_delay_line.sv
module sg_delay_line #(
   parameter int   DEPTH   = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sg_delay_line: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] dl_q;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dl_q <= RST_VAL;
            else        dl_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dl_q <= {DEPTH{RST_VAL}};
            else        dl_q <= {dl_q[DEPTH-2:0], d};
         end
      end
   endgenerate

   assign q = dl_q[DEPTH-1];
endmodule

// File: rtl/sg_run_ctrl.sv
module sg_run_ctrl
   import stop_gate_pkg::*;
#(
   parameter int MIN_RUN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   input  logic keep_req,
   input  logic force_s,
   output logic en_req
);
   localparam int CW = $clog2(MIN_RUN + 1);
   localparam logic [CW-1:0] RUN_TGT  = CW'(MIN_RUN);
   localparam logic [CW-1:0] RUN_LAST = CW'(MIN_RUN - 1);

   generate
      if (MIN_RUN < 1) begin : g_bad_run
         $error("sg_run_ctrl: MIN_RUN must be at least 1");
      end
   endgenerate

   gate_state_e   state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d, cnt_inc;

   always_comb begin
      cnt_inc = (cnt_q == RUN_TGT) ? cnt_q : cnt_q + 1'b1;
      state_d = state_q;
      cnt_d   = cnt_q;
      case (state_q)
         GATE_PARKED: begin
            cnt_d = '0;
            if (run_req && !force_s) state_d = GATE_RUNNING;
         end
         GATE_RUNNING: begin
            cnt_d = cnt_inc;
            if (force_s || (!keep_req && cnt_inc == RUN_TGT)) begin
               state_d = GATE_PARKED;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = GATE_PARKED;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GATE_PARKED;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign en_req = (state_q == GATE_RUNNING);

   // R7
   min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_req) && !$past(force_s)) |-> ($past(cnt_q) >= RUN_LAST))
      else $error("min run violated");

   // R9
   force_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_s |=> !en_req)
      else $error("force did not park");

   // R10
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_req) |-> ($past(run_req) && !$past(force_s)))
      else $error("start without request");

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RUN_TGT)
      else $error("run counter overflow");
endmodule

// File: rtl/sg_gate.sv
module sg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   output logic clk_gated
);
   logic en_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_req;
   end

   assign clk_gated = clk & en_q;

   // R3
   phase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q == en_req)
      else $error("enable changed outside low phase");
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_RUN     = 10,
   parameter int ON_EXTRA    = 0,
   parameter int OFF_EXTRA   = 0
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic stop_n,
   input  logic force_low,
   output logic clk_gated,
   output logic clk_free
);
   generate
      if (ON_EXTRA < 0 || OFF_EXTRA < 0) begin : g_bad_extra
         $error("clk_stop_gate: extra delays must not be negative");
      end
   endgenerate

   logic run_s, force_s, on_tap, off_tap, en_req;

   sg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stop_sync (
      .clk(clk_in), .rst_n(rst_n), .d(stop_n), .q(run_s));

   sg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_force_sync (
      .clk(clk_in), .rst_n(rst_n), .d(force_low), .q(force_s));

   generate
      if (ON_EXTRA == 0) begin : g_on_direct
         assign on_tap = run_s;
      end else begin : g_on_delay
         sg_delay_line #(.DEPTH(ON_EXTRA), .RST_VAL(1'b0)) u_on_dl (
            .clk(clk_in), .rst_n(rst_n), .d(run_s), .q(on_tap));
      end
      if (OFF_EXTRA == 0) begin : g_off_direct
         assign off_tap = run_s;
      end else begin : g_off_delay
         sg_delay_line #(.DEPTH(OFF_EXTRA), .RST_VAL(1'b0)) u_off_dl (
            .clk(clk_in), .rst_n(rst_n), .d(run_s), .q(off_tap));
      end
   endgenerate

   sg_run_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
      .clk(clk_in), .rst_n(rst_n), .run_req(on_tap), .keep_req(off_tap),
      .force_s(force_s), .en_req(en_req));

   sg_gate u_gate (
      .clk(clk_in), .rst_n(rst_n), .en_req(en_req), .clk_gated(clk_gated));

   assign clk_free = clk_in;
endmodule

// File: tb/sim_clk_stop_gate.sv
module sim_clk_stop_gate;
   localparam int PERIOD = 10;
   localparam int HALF   = PERIOD / 2;

   logic clk_in = 1'b0;
   logic rst_n, stop_n, force_low;
   logic clk_gated, clk_free;

   int n_chk  = 0;
   int n_err  = 0;
   logic  q_v[$];
   string q_t[$];

   clk_stop_gate u0 (
      .clk_in(clk_in), .rst_n(rst_n), .stop_n(stop_n), .force_low(force_low),
      .clk_gated(clk_gated), .clk_free(clk_free));

   always #(HALF) clk_in = ~clk_in;

   task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   // driver: push one expected bit per coming edge, then step past that edge
   task automatic expect_edges(input logic v, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         q_v.push_back(v);
         q_t.push_back(tag);
         @(negedge clk_in);
      end
   endtask

   task automatic apply(input logic s, input logic f);
      stop_n    = s;
      force_low = f;
   endtask

   // monitor: pop and compare early and late in the high phase
   always @(posedge clk_in) begin
      #1;
      chk(clk_free === 1'b1, "R2", clk_free, 1'b1);
      if (q_v.size() > 0) begin
         logic  ev;
         string et;
         ev = q_v.pop_front();
         et = q_t.pop_front();
         chk(clk_gated === ev, et, clk_gated, ev);
         #(HALF - 2);
         if (ev) chk(clk_gated === 1'b1, "R3", clk_gated, 1'b1);
      end
   end

   always @(negedge clk_in) begin
      #1;
      chk(clk_gated === 1'b0, "R3", clk_gated, 1'b0);
      chk(clk_free === 1'b0, "R2", clk_free, 1'b0);
   end

   always @(posedge clk_gated) chk(clk_in === 1'b1, "R3", clk_in, 1'b1);
   always @(negedge clk_gated) chk(clk_in === 1'b0, "R3", clk_in, 1'b0);

   initial begin
      rst_n = 1'b0;
      apply(1'b1, 1'b0);
      fork
         begin
            @(negedge clk_in);
            expect_edges(1'b0, 3, "R1");       // held in reset
            rst_n = 1'b1;
            expect_edges(1'b0, 3, "R1");       // start latency after reset
            expect_edges(1'b1, 17, "R6");
            apply(1'b0, 1'b0);                 // stop, min run met
            expect_edges(1'b1, 3, "R5");
            expect_edges(1'b0, 7, "R4");
            apply(1'b1, 1'b0);                 // restart
            expect_edges(1'b0, 3, "R6");
            expect_edges(1'b1, 1, "R6");
            apply(1'b0, 1'b0);                 // early stop, deferred
            expect_edges(1'b1, 9, "R7");
            expect_edges(1'b0, 6, "R7");
            apply(1'b1, 1'b0);
            expect_edges(1'b0, 3, "R6");
            expect_edges(1'b1, 12, "R6");
            apply(1'b0, 1'b0);                 // single-edge stop pulse
            expect_edges(1'b1, 1, "R8");
            apply(1'b1, 1'b0);
            expect_edges(1'b1, 2, "R8");
            expect_edges(1'b0, 1, "R8");
            expect_edges(1'b1, 3, "R8");
            apply(1'b1, 1'b1);                 // force inside min run
            expect_edges(1'b1, 3, "R9");
            expect_edges(1'b0, 5, "R9");
            apply(1'b1, 1'b0);                 // release force
            expect_edges(1'b0, 3, "R10");
            expect_edges(1'b1, 5, "R10");
            apply(1'b1, 1'b1);
            expect_edges(1'b1, 3, "R9");
            expect_edges(1'b0, 7, "R9");
            apply(1'b0, 1'b1);                 // stop_n toggled under force
            expect_edges(1'b0, 5, "R10");
            apply(1'b1, 1'b1);
            expect_edges(1'b0, 5, "R10");
            apply(1'b1, 1'b0);
            expect_edges(1'b0, 3, "R10");
            expect_edges(1'b1, 7, "R10");
            @(negedge clk_in);
            chk(q_v.size() == 0, "R4", 1'b0, 1'b0);
         end
         begin
            #(PERIOD * 5000);
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired: actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule